// File: doc/BRIEF.md
# Stream Buffer Arbiter

The block holds stream data in a wide on-chip array, where each row is half a stream buffer wide. Each client has a private stream buffer of `BUF_DEPTH` words. Clients never address the array. A client opens a logical stream by pulsing a start strobe with a descriptor and a direction. The descriptor gives the first array row, a length in records and a record size in words. After that the client moves one word per cycle through a valid/ready handshake.

A round-robin block mover shares the array among the buffers. The mover works in two-cycle slots. In the first cycle of a slot it picks one buffer that needs service. In the second cycle it moves one half-buffer block between that buffer and the array.
- For a read stream, the mover prefetches the next row into the buffer once half the buffer is free.
- For a write stream, the mover drains a full half once it has filled.
- A write stream that ends early flushes its final partial block. Only the words the client actually wrote are stored.

Top module: `srf_stream_arb`

## Requirements
- R1: While reset is held and after it is released, every client shows busy, rd_valid, wr_ready, err and done all low.
- R2: A start on an idle client is accepted and busy rises one cycle later. The stream covers len×rec words starting at word address base×(BUF_DEPTH/2). dir=0 selects a read stream and dir=1 a write stream.
- R3: The array moves at most one block per two-cycle slot. The block goes to a single buffer that requested service, and no transfer happens in two consecutive cycles.
- R4: A read stream delivers exactly len×rec words, in address order, equal to the array contents. rd_valid stays high while the buffer holds data, and one word moves in each cycle that rd_ready is high.
- R5: A write stream accepts a word in every cycle where wr_ready and wr_valid are both high. wr_ready stays high while the buffer has room and the stream is still open. The i-th word is stored at the stream's word address plus i.
- R6: The direction is fixed for the whole stream. A read stream never raises wr_ready, a write stream never raises rd_valid, and an idle client raises neither.
- R7: A write stream closes after len×rec words or on an eos strobe, whichever comes first. wr_ready then stays low. The final partial block is stored, and the array words past the last written word are left unchanged.
- R8: done pulses for one cycle, and busy falls in the same cycle. For a read stream this happens after the last word is delivered. For a write stream it happens after the last data reaches the array.
- R9: A start on a busy client produces a one-cycle err pulse in the next cycle. The descriptor is ignored and the running stream continues unchanged.
- R10: Buffers that request service are granted in round-robin order, so several concurrent streams on different clients all complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | N_CLI | Per-client start strobe |
| dir_i | input | N_CLI | Per-client direction, 0 read, 1 write |
| base_i | input | N_CLI*ROW_W | Per-client first array row |
| len_i | input | N_CLI*LEN_W | Per-client length in records |
| rec_i | input | N_CLI*REC_W | Per-client record size in words |
| busy_o | output | N_CLI | Stream open on the client |
| err_o | output | N_CLI | Start was rejected because the client was busy |
| done_o | output | N_CLI | Stream completed |
| rd_valid_o | output | N_CLI | Read word available |
| rd_ready_i | input | N_CLI | Client takes a read word |
| rd_data_o | output | N_CLI*WORD_W | Read word |
| wr_valid_i | input | N_CLI | Client offers a write word |
| wr_ready_o | output | N_CLI | Buffer accepts a write word |
| wr_data_i | input | N_CLI*WORD_W | Write word |
| eos_i | input | N_CLI | Ends a write stream early |

## Verification
The bench keeps its own word-addressed copy of the array and checks every delivered read word against it. It runs four streams at once, with random stalls on the read side, so a mover that starves a buffer or loses a slot would hang or misorder data.

Several corner cases are targeted directly:
- An early eos after seven words is followed by a full read-back of that row. A flush that wrote a whole row would overwrite the 25 old words behind the new ones.
- Lengths that are not a multiple of the block size exercise the partial last fill and drain. An off-by-one here would show up as extra or missing words, or as a done pulse that arrives with words still outstanding.
- A restart on a busy client must produce err and leave the running stream's data intact.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } srf_dir_e;
endpackage

// File: rtl/srf_rr_arb.sv
module srf_rr_arb #(
  parameter int N_CLI = 4,
  localparam int IW = (N_CLI > 1) ? $clog2(N_CLI) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CLI-1:0] req_i,
  input  logic             adv_i,
  output logic             vld_o,
  output logic [IW-1:0]    idx_o
);
  logic [IW-1:0] last_q;

  // search from last+1 upward; nearest requester wins
  always_comb begin
    int cand;
    vld_o = 1'b0;
    idx_o = last_q;
    for (int off = N_CLI; off >= 1; off--) begin
      cand = (int'(last_q) + off) % N_CLI;
      if (req_i[cand]) begin
        vld_o = 1'b1;
        idx_o = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= IW'(N_CLI - 1);
    else if (adv_i && vld_o) last_q <= idx_o;

  assert_grant_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> req_i[idx_o]);
endmodule

// File: rtl/srf_stream_buf.sv
module srf_stream_buf
  import srf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 64,
  parameter int ROW_W  = 4,
  parameter int LEN_W  = 8,
  parameter int REC_W  = 3,
  localparam int BLK   = DEPTH / 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int TOT_W = LEN_W + REC_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        dir_i,
  input  logic [ROW_W-1:0]            base_i,
  input  logic [LEN_W-1:0]            len_i,
  input  logic [REC_W-1:0]            rec_i,
  output logic                        busy_o,
  output logic                        err_o,
  output logic                        done_o,
  output logic                        rd_valid_o,
  input  logic                        rd_ready_i,
  output logic [WORD_W-1:0]           rd_data_o,
  input  logic                        wr_valid_i,
  output logic                        wr_ready_o,
  input  logic [WORD_W-1:0]           wr_data_i,
  input  logic                        eos_i,
  output logic                        req_o,
  input  logic                        xfer_i,
  output logic [ROW_W-1:0]            row_o,
  output logic                        is_wr_o,
  input  logic [BLK-1:0][WORD_W-1:0]  fill_row_i,
  output logic [BLK-1:0][WORD_W-1:0]  drain_row_o,
  output logic [CNT_W-1:0]            drain_n_o
);
  logic              active_q, closing_q, err_q, done_q;
  srf_dir_e          dir_q;
  logic [ROW_W-1:0]  row_q;
  logic [TOT_W-1:0]  fill_left_q, out_left_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, fill_n, xfer_n;
  logic [PTR_W-1:0]  rptr_q, wptr_q, rptr_nxt, wptr_nxt, fill_base, drain_base;
  logic [WORD_W-1:0] fifo_q [DEPTH];
  logic [TOT_W-1:0]  tot;
  logic              is_rd, is_wr, push, pop, xfer_rd, xfer_wr;

  assign is_rd   = active_q && dir_q == DIR_RD;
  assign is_wr   = active_q && dir_q == DIR_WR;
  assign tot     = TOT_W'(len_i) * TOT_W'(rec_i);

  assign rd_valid_o = is_rd && cnt_q != '0;
  assign rd_data_o  = fifo_q[rptr_q];
  assign wr_ready_o = is_wr && !closing_q && cnt_q != CNT_W'(DEPTH) && out_left_q != '0;
  assign pop  = rd_valid_o && rd_ready_i;
  assign push = wr_ready_o && wr_valid_i;

  assign fill_n    = (fill_left_q >= TOT_W'(BLK)) ? CNT_W'(BLK) : CNT_W'(fill_left_q);
  assign drain_n_o = (cnt_q >= CNT_W'(BLK)) ? CNT_W'(BLK) : cnt_q;
  assign xfer_n    = is_rd ? fill_n : drain_n_o;
  assign xfer_rd   = xfer_i && is_rd;
  assign xfer_wr   = xfer_i && is_wr;

  // read needs room for a whole half; write needs a full half or a final flush
  assign req_o = (is_rd && fill_left_q != '0 && (CNT_W'(DEPTH) - cnt_q) >= CNT_W'(BLK)) ||
                 (is_wr && (cnt_q >= CNT_W'(BLK) || (closing_q && cnt_q != '0)));

  assign row_o   = row_q;
  assign is_wr_o = is_wr;
  assign busy_o  = active_q;
  assign err_o   = err_q;
  assign done_o  = done_q;

  // blocks always sit on half boundaries
  assign fill_base  = {wptr_q[PTR_W-1], {(PTR_W-1){1'b0}}};
  assign drain_base = {rptr_q[PTR_W-1], {(PTR_W-1){1'b0}}};

  always_comb
    for (int k = 0; k < BLK; k++) drain_row_o[k] = fifo_q[drain_base + PTR_W'(k)];

  assign cnt_nxt  = cnt_q + CNT_W'(push) - CNT_W'(pop)
                  + (xfer_rd ? xfer_n : '0) - (xfer_wr ? xfer_n : '0);
  assign rptr_nxt = rptr_q + PTR_W'(pop) + (xfer_wr ? PTR_W'(xfer_n) : '0);
  assign wptr_nxt = wptr_q + PTR_W'(push) + (xfer_rd ? PTR_W'(xfer_n) : '0);

  always_ff @(posedge clk_i) begin
    if (push) fifo_q[wptr_q] <= wr_data_i;
    if (xfer_rd)
      for (int k = 0; k < BLK; k++)
        if (CNT_W'(k) < fill_n) fifo_q[fill_base + PTR_W'(k)] <= fill_row_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      closing_q   <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      dir_q       <= DIR_RD;
      row_q       <= '0;
      fill_left_q <= '0;
      out_left_q  <= '0;
      cnt_q       <= '0;
      rptr_q      <= '0;
      wptr_q      <= '0;
    end else begin
      err_q  <= start_i && active_q;
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q    <= 1'b1;
        dir_q       <= srf_dir_e'(dir_i);
        row_q       <= base_i;
        fill_left_q <= dir_i ? '0 : tot;
        out_left_q  <= tot;
        closing_q   <= 1'b0;
        cnt_q       <= '0;
        rptr_q      <= '0;
        wptr_q      <= '0;
      end else if (active_q) begin
        cnt_q  <= cnt_nxt;
        rptr_q <= rptr_nxt;
        wptr_q <= wptr_nxt;
        if (xfer_i) row_q <= row_q + 1'b1;
        if (xfer_rd) fill_left_q <= fill_left_q - TOT_W'(fill_n);
        if (push || pop) out_left_q <= out_left_q - 1'b1;
        if ((push && out_left_q == TOT_W'(1)) || (is_wr && eos_i)) closing_q <= 1'b1;
        if ((is_rd && out_left_q == '0) || (is_wr && closing_q && cnt_q == '0)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_xfer_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |-> $past(req_o));
  assert_err_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(busy_o) && $past(start_i));
  assert_done_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o);
endmodule

// File: rtl/srf_stream_arb.sv
module srf_stream_arb
  import srf_pkg::*;
#(
  parameter int N_CLI  = 4,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 64,
  parameter int ROWS   = 16,
  parameter int LEN_W  = 8,
  parameter int REC_W  = 3,
  localparam int ROW_W = $clog2(ROWS),
  localparam int BLK   = DEPTH / 2,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int IW    = (N_CLI > 1) ? $clog2(N_CLI) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CLI-1:0]          start_i,
  input  logic [N_CLI-1:0]          dir_i,
  input  logic [N_CLI*ROW_W-1:0]    base_i,
  input  logic [N_CLI*LEN_W-1:0]    len_i,
  input  logic [N_CLI*REC_W-1:0]    rec_i,
  output logic [N_CLI-1:0]          busy_o,
  output logic [N_CLI-1:0]          err_o,
  output logic [N_CLI-1:0]          done_o,
  output logic [N_CLI-1:0]          rd_valid_o,
  input  logic [N_CLI-1:0]          rd_ready_i,
  output logic [N_CLI*WORD_W-1:0]   rd_data_o,
  input  logic [N_CLI-1:0]          wr_valid_i,
  output logic [N_CLI-1:0]          wr_ready_o,
  input  logic [N_CLI*WORD_W-1:0]   wr_data_i,
  input  logic [N_CLI-1:0]          eos_i
);
  logic [BLK-1:0][WORD_W-1:0] mem_q [ROWS];
  logic [N_CLI-1:0][BLK-1:0][WORD_W-1:0] drain_rows;
  logic [N_CLI-1:0][CNT_W-1:0] drain_ns;
  logic [N_CLI-1:0][ROW_W-1:0] rows;
  logic [N_CLI-1:0]            req, is_wr, xfer;
  logic [BLK-1:0][WORD_W-1:0]  fill_row;
  logic                        ph_q, gnt_vld_q, arb_vld;
  logic [IW-1:0]               gnt_idx_q, arb_idx;
  logic [ROW_W-1:0]            sel_row;

  srf_rr_arb #(.N_CLI(N_CLI)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .adv_i(!ph_q),
    .vld_o(arb_vld), .idx_o(arb_idx)
  );

  // slot: phase 0 picks a buffer, phase 1 moves its block
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ph_q      <= 1'b0;
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= '0;
    end else begin
      ph_q <= !ph_q;
      if (!ph_q) begin
        gnt_vld_q <= arb_vld;
        gnt_idx_q <= arb_idx;
      end else begin
        gnt_vld_q <= 1'b0;
      end
    end

  always_comb begin
    xfer = '0;
    if (ph_q && gnt_vld_q) xfer[gnt_idx_q] = 1'b1;
  end

  assign sel_row  = rows[gnt_idx_q];
  assign fill_row = mem_q[sel_row];

  always_ff @(posedge clk_i)
    if (ph_q && gnt_vld_q && is_wr[gnt_idx_q])
      for (int k = 0; k < BLK; k++)
        if (CNT_W'(k) < drain_ns[gnt_idx_q]) mem_q[sel_row][k] <= drain_rows[gnt_idx_q][k];

  for (genvar c = 0; c < N_CLI; c++) begin : g_cli
    srf_stream_buf #(
      .WORD_W(WORD_W), .DEPTH(DEPTH), .ROW_W(ROW_W), .LEN_W(LEN_W), .REC_W(REC_W)
    ) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i[c]),
      .dir_i      (dir_i[c]),
      .base_i     (base_i[c*ROW_W +: ROW_W]),
      .len_i      (len_i[c*LEN_W +: LEN_W]),
      .rec_i      (rec_i[c*REC_W +: REC_W]),
      .busy_o     (busy_o[c]),
      .err_o      (err_o[c]),
      .done_o     (done_o[c]),
      .rd_valid_o (rd_valid_o[c]),
      .rd_ready_i (rd_ready_i[c]),
      .rd_data_o  (rd_data_o[c*WORD_W +: WORD_W]),
      .wr_valid_i (wr_valid_i[c]),
      .wr_ready_o (wr_ready_o[c]),
      .wr_data_i  (wr_data_i[c*WORD_W +: WORD_W]),
      .eos_i      (eos_i[c]),
      .req_o      (req[c]),
      .xfer_i     (xfer[c]),
      .row_o      (rows[c]),
      .is_wr_o    (is_wr[c]),
      .fill_row_i (fill_row),
      .drain_row_o(drain_rows[c]),
      .drain_n_o  (drain_ns[c])
    );
  end

  assert_one_xfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(xfer));
  assert_slot_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|xfer) |=> !(|xfer));
endmodule

// File: tb/srf_stream_arb_bench.sv
`timescale 1ns/1ps
module srf_stream_arb_bench;
  localparam int N = 4, WW = 16, RW = 4, LW = 8, CW = 3, BLK = 32;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, fin = 1'b0;
  always #2.5 clk = !clk;

  logic [N-1:0] start_i = '0, dir_i = '0, rd_ready_i = '0, wr_valid_i = '0, eos_i = '0;
  logic [N*RW-1:0] base_i = '0;
  logic [N*LW-1:0] len_i = '0;
  logic [N*CW-1:0] rec_i = '0;
  logic [N*WW-1:0] wr_data_i = '0;
  logic [N-1:0] busy_o, err_o, done_o, rd_valid_o, wr_ready_o;
  logic [N*WW-1:0] rd_data_o;

  srf_stream_arb u_srf_stream_arb (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .dir_i(dir_i), .base_i(base_i),
    .len_i(len_i), .rec_i(rec_i), .busy_o(busy_o), .err_o(err_o), .done_o(done_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i), .eos_i(eos_i)
  );

  int checks = 0, errors = 0;
  int model [512];
  int act [N], isw [N], sbase [N], total [N], idx [N], eos_at [N], thr [N], seed [N];
  int closed [N], eos_pend [N], exp_err [N], exp_busy [N];
  int p_go [N], p_w [N], p_base [N], p_len [N], p_rec [N], p_eos [N], p_thr [N], p_seed [N];

  task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  initial for (int c = 0; c < N; c++) begin
    act[c] = 0; p_go[c] = 0; exp_err[c] = 0; exp_busy[c] = 0;
  end

  // reference engine: drives clients and compares outputs every clock
  always @(negedge clk) if (run) begin
    for (int c = 0; c < N; c++) begin
      logic [WW-1:0] d;
      int a;
      chk(err_o[c] === exp_err[c][0], "R9", "err pulse", int'(err_o[c]), exp_err[c]);
      if (exp_busy[c] != 0) chk(busy_o[c] === 1'b1, "R2", "busy after start", int'(busy_o[c]), 1);
      exp_busy[c] = 0;
      if (!busy_o[c])
        chk(!rd_valid_o[c] && !wr_ready_o[c], "R6", "idle handshake", int'({rd_valid_o[c], wr_ready_o[c]}), 0);
      if (act[c] != 0 && isw[c] != 0) chk(!rd_valid_o[c], "R6", "rd_valid on write", int'(rd_valid_o[c]), 0);
      if (act[c] != 0 && isw[c] == 0) chk(!wr_ready_o[c], "R6", "wr_ready on read", int'(wr_ready_o[c]), 0);
      if (done_o[c]) begin
        if (isw[c] != 0) chk(act[c] != 0 && closed[c] != 0 && eos_pend[c] == 0, "R8", "write done early", idx[c], total[c]);
        else chk(act[c] != 0 && idx[c] == total[c], "R8", "read done count", idx[c], total[c]);
        chk(!busy_o[c], "R8", "busy with done", int'(busy_o[c]), 0);
        act[c] = 0;
      end
      start_i[c] = 1'b0; rd_ready_i[c] = 1'b0; wr_valid_i[c] = 1'b0; eos_i[c] = 1'b0;
      if (act[c] != 0 && isw[c] == 0 && rd_valid_o[c]) begin
        if (thr[c] == 0 || $urandom_range(2) != 0) begin
          a = sbase[c] * BLK + idx[c];
          chk(idx[c] < total[c], "R4", "extra read word", idx[c], total[c]);
          chk(rd_data_o[c*WW +: WW] === WW'(model[a]), "R4", "read data",
              int'(rd_data_o[c*WW +: WW]), model[a]);
          rd_ready_i[c] = 1'b1;
          idx[c]++;
        end
      end
      if (act[c] != 0 && isw[c] != 0) begin
        if (closed[c] != 0) chk(!wr_ready_o[c], "R7", "wr_ready after close", int'(wr_ready_o[c]), 0);
        else if (eos_pend[c] != 0) begin
          eos_i[c] = 1'b1; eos_pend[c] = 0; closed[c] = 1;
        end else if (wr_ready_o[c]) begin
          d = WW'((c << 12) ^ (seed[c] * 37 + idx[c] * 5));
          wr_valid_i[c] = 1'b1;
          wr_data_i[c*WW +: WW] = d;
          model[sbase[c] * BLK + idx[c]] = int'(d);
          idx[c]++;
          if (idx[c] == eos_at[c]) eos_pend[c] = 1;
          if (idx[c] == total[c]) closed[c] = 1;
        end
      end
      exp_err[c] = 0;
      if (p_go[c] != 0) begin
        start_i[c] = 1'b1;
        dir_i[c] = p_w[c][0];
        base_i[c*RW +: RW] = RW'(p_base[c]);
        len_i[c*LW +: LW] = LW'(p_len[c]);
        rec_i[c*CW +: CW] = CW'(p_rec[c]);
        exp_err[c] = int'(busy_o[c]);
        if (!busy_o[c]) begin
          act[c] = 1; isw[c] = p_w[c]; sbase[c] = p_base[c]; total[c] = p_len[c] * p_rec[c];
          idx[c] = 0; eos_at[c] = p_eos[c]; thr[c] = p_thr[c]; seed[c] = p_seed[c];
          closed[c] = 0; eos_pend[c] = 0; exp_busy[c] = 1;
        end
        p_go[c] = 0;
      end
    end
  end

  task automatic go(input int c, input int w, input int b, input int l, input int r,
                    input int e, input int t, input int s);
    @(posedge clk);
    p_w[c] = w; p_base[c] = b; p_len[c] = l; p_rec[c] = r;
    p_eos[c] = e; p_thr[c] = t; p_seed[c] = s; p_go[c] = 1;
  endtask

  task automatic wait_idle();
    int any;
    do begin
      @(posedge clk);
      any = 0;
      for (int c = 0; c < N; c++) if (act[c] != 0 || p_go[c] != 0) any = 1;
    end while (any != 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #200000;
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == '0 && rd_valid_o == '0 && wr_ready_o == '0 && err_o == '0 && done_o == '0,
        "R1", "outputs in reset", int'({busy_o, rd_valid_o, wr_ready_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == '0 && rd_valid_o == '0 && wr_ready_o == '0 && err_o == '0 && done_o == '0,
        "R1", "outputs after reset", int'({busy_o, rd_valid_o, wr_ready_o}), 0);
    run = 1'b1;
    // R5 R10: three concurrent writes with partial last blocks
    go(0, 1, 2, 20, 3, -1, 0, 1);
    go(3, 1, 5, 32, 1, -1, 0, 2);
    go(1, 1, 8, 50, 2, -1, 0, 3);
    repeat (6) @(posedge clk);
    go(1, 0, 12, 4, 1, -1, 0, 9);   // R9: rejected restart while busy
    wait_idle();
    // R7: early end, 7 words into row 5
    go(1, 1, 5, 20, 2, 7, 0, 4);
    wait_idle();
    // R4 R10: four concurrent reads, some throttled
    go(0, 0, 8, 100, 1, -1, 1, 0);
    go(1, 0, 2, 30, 2, -1, 0, 0);
    go(2, 0, 5, 32, 1, -1, 1, 0);
    go(3, 0, 2, 10, 1, -1, 0, 0);
    repeat (10) @(posedge clk);
    go(2, 1, 0, 1, 1, -1, 0, 0);    // R9: rejected during read
    wait_idle();
    // R6: same buffer reused in the other direction, single word
    go(2, 1, 14, 1, 1, -1, 0, 5);
    wait_idle();
    go(2, 0, 14, 1, 1, -1, 0, 0);
    wait_idle();
    run = 1'b0;
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule